// File: doc/BRIEF.md
# Switch Matrix Row Interconnect Self-Test

This block models a row of configurable routing switch matrices, each with K pins on every side (north, east, south, west). A pin with index i on one side can be joined only to the pins with the same index i on the other sides. For a test, every matrix is forced into the same one of three fixed joining patterns. The joined pins of the whole row then form one wide bus of 2·K·M wires, and a built-in pattern generator and checker exercise that bus.

Each wire w of the bus gets the code w+1. The code has CW = ceil(log2(2·K·M+2)) bits, so it is never zero and never all ones. Vector j drives bit j of every wire's code into that wire's driving pin. The checker compares each receiving pin with the expected bit and sets a sticky fail flag on any mismatch. With the defaults (K=4, M=5) the bus is 40 wires wide and a run takes 6 vectors.

Fault controls inject one of four defects: a line open, a short between two lines, a permanent connection between two pins of a matrix, or a permanent disconnection of a joined pin pair. A line open holds the receiving end of its wire at 0. Shorts and permanent connections behave as a wired-AND of the two wires involved.

Top module: `sm_row_ictest`

## Requirements
- R1: After reset, done, fail and pass are all low.
- R2: A start accepted while no run is in progress raises done exactly CW clock edges after the edge that samples start. Done then stays high until the next accepted start, and it is low during the run.
- R3: The mode selects the joining pattern: 0 joins W_i to E_i and N_i to S_i, 1 joins W_i to N_i and S_i to E_i, 2 joins W_i to S_i and N_i to E_i. Value 3 acts as mode 0. With no fault enabled, every mode ends with pass high and fail low.
- R4: A line open on any wire index 0..2KM-1 ends the run with fail high.
- R5: A line-pair short between two distinct wire indices ends the run with fail high. A short that names the same wire twice has no effect, and pass ends high.
- R6: A permanent connection inside a matrix between two pins that are not joined by the current mode ends the run with fail high. Between the two pins that the mode does join, it has no effect, and pass ends high. A pin is encoded as side·K+i, with side N=0, E=1, S=2, W=3.
- R7: A permanent disconnection of a pin pair that the current mode joins ends the run with fail high. For any other pin pair it has no effect, and pass ends high.
- R8: Fail is sticky for the rest of a run, is cleared by the next accepted start, and pass equals done with fail low.
- R9: A start pulse during a run is ignored. The run keeps its mode and its completion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test run (sampled when no run is in progress) |
| mode | input | 2 | Joining pattern, captured at start |
| open_en | input | 1 | Enable line-open fault |
| open_wire | input | 6 | Wire whose receiving end is held at 0 |
| short_en | input | 1 | Enable line-pair short |
| short_a | input | 6 | First shorted wire |
| short_b | input | 6 | Second shorted wire |
| pconn_en | input | 1 | Enable permanent-connection fault |
| pconn_mtx | input | 3 | Matrix holding the permanent connection |
| pconn_pa | input | 4 | First pin (side·K+i) |
| pconn_pb | input | 4 | Second pin (side·K+i) |
| pdisc_en | input | 1 | Enable permanent-disconnection fault |
| pdisc_mtx | input | 3 | Matrix holding the disconnection |
| pdisc_pa | input | 4 | First pin of the pair |
| pdisc_pb | input | 4 | Second pin of the pair |
| done | output | 1 | Run complete |
| fail | output | 1 | Sticky mismatch flag |
| pass | output | 1 | Run complete with no mismatch |

## Verification
The assertions assume that the fault controls stay fixed while a run is in progress. They also assume that the wire, matrix and pin indices stay within the row, so the clean-fabric property ties received values to driven values only when every fault is disabled. The stimulus changes fault controls only between runs and draws every index with a modulo of the row's true size. Random trials mix the three modes and the reserved mode value with each fault kind. Directed cases aim at the joined pairs, where a connection is redundant and a disconnection is visible.

// File: rtl/sm_ictest_pkg.sv
package sm_ictest_pkg;

    typedef enum logic [1:0] {
        CFG_ORTHO = 2'd0,
        CFG_DIAG1 = 2'd1,
        CFG_DIAG2 = 2'd2,
        CFG_RSVD  = 2'd3
    } cfg_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_t;

    localparam int SIDE_N = 0;
    localparam int SIDE_E = 1;
    localparam int SIDE_S = 2;
    localparam int SIDE_W = 3;

    // Side joined to the west pin in each configuration
    function automatic int west_partner(cfg_mode_t md);
        case (md)
            CFG_DIAG1: return SIDE_N;
            CFG_DIAG2: return SIDE_S;
            default:   return SIDE_E;
        endcase
    endfunction

endpackage

// File: rtl/sm_seq_ctl.sv
module sm_seq_ctl
    import sm_ictest_pkg::*;
#(
    parameter int K = 4,
    parameter int M = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          mode_in,
    output logic                run,
    output logic                clear,
    output logic                done,
    output cfg_mode_t           mode_q,
    output logic [CWI-1:0]      vec_idx,
    output logic [2*K*M-1:0]    drv
);
    localparam int NW  = 2 * K * M;
    localparam int CW  = $clog2(NW + 2);
    localparam int CWI = (CW > 1) ? $clog2(CW) : 1;

    typedef struct packed {
        run_state_t     st;
        logic [CWI-1:0] idx;
        cfg_mode_t      md;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic accept;

    always_comb begin
        ctl_d  = ctl_q;
        accept = start && (ctl_q.st != ST_RUN);
        if (accept) begin
            ctl_d.st  = ST_RUN;
            ctl_d.idx = '0;
            ctl_d.md  = cfg_mode_t'(mode_in);
        end else if (ctl_q.st == ST_RUN) begin
            if (ctl_q.idx == CWI'(CW - 1)) begin
                ctl_d.st = ST_DONE;
            end else begin
                ctl_d.idx = ctl_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, idx: '0, md: CFG_ORTHO};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign run     = (ctl_q.st == ST_RUN);
    assign done    = (ctl_q.st == ST_DONE);
    assign clear   = accept;
    assign mode_q  = ctl_q.md;
    assign vec_idx = ctl_q.idx;

    // Counting-code generator: wire w carries code w+1, vector j drives bit j
    for (genvar w = 0; w < NW; w++) begin : g_code
        localparam logic [CW-1:0] CODE = CW'(w + 1);
        assign drv[w] = CODE[ctl_q.idx];
    end

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (vec_idx < CWI'(CW)));

    // R2
    run_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(run));

    // R2
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(start));

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(mode_q));

endmodule

// File: rtl/sm_fabric.sv
module sm_fabric
    import sm_ictest_pkg::*;
#(
    parameter int K = 4,
    parameter int M = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  cfg_mode_t           mode,
    input  logic [2*K*M-1:0]    drv,
    input  logic                open_en,
    input  logic [WIW-1:0]      open_wire,
    input  logic                short_en,
    input  logic [WIW-1:0]      short_a,
    input  logic [WIW-1:0]      short_b,
    input  logic                pconn_en,
    input  logic [MIW-1:0]      pconn_mtx,
    input  logic [PIW-1:0]      pconn_pa,
    input  logic [PIW-1:0]      pconn_pb,
    input  logic                pdisc_en,
    input  logic [MIW-1:0]      pdisc_mtx,
    input  logic [PIW-1:0]      pdisc_pa,
    input  logic [PIW-1:0]      pdisc_pb,
    output logic [2*K*M-1:0]    rcv
);
    localparam int NW  = 2 * K * M;
    localparam int SEG = 2 * K;
    localparam int WIW = $clog2(NW);
    localparam int MIW = (M > 1) ? $clog2(M) : 1;
    localparam int PIW = $clog2(4 * K);

    // Local wire of a pin inside one matrix: pair 0 holds the west pin
    function automatic int local_wire(cfg_mode_t md, int pin);
        int side;
        int idx;
        int half;
        side = pin / K;
        idx  = pin % K;
        half = ((side == SIDE_W) || (side == west_partner(md))) ? 0 : 1;
        return half * K + idx;
    endfunction

    logic [NW-1:0] line_v;

    // Line-pair short: wired-AND across the whole bus
    always_comb begin
        line_v = drv;
        if (short_en && (int'(short_a) < NW) && (int'(short_b) < NW) &&
            (short_a != short_b)) begin
            line_v[short_a] = drv[short_a] & drv[short_b];
            line_v[short_b] = drv[short_a] & drv[short_b];
        end
    end

    for (genvar g = 0; g < M; g++) begin : g_mtx
        localparam int BASE = g * SEG;
        logic [SEG-1:0] seg_in;
        logic [SEG-1:0] seg_mrg;
        logic [SEG-1:0] seg_out;
        int ca, cb, da, db;

        assign seg_in = line_v[BASE +: SEG];

        always_comb begin
            ca      = local_wire(mode, int'(pconn_pa));
            cb      = local_wire(mode, int'(pconn_pb));
            da      = local_wire(mode, int'(pdisc_pa));
            db      = local_wire(mode, int'(pdisc_pb));
            seg_mrg = seg_in;
            if (pconn_en && (int'(pconn_mtx) == g) && (ca != cb) &&
                (int'(pconn_pa) < 4 * K) && (int'(pconn_pb) < 4 * K)) begin
                seg_mrg[ca] = seg_in[ca] & seg_in[cb];
                seg_mrg[cb] = seg_in[ca] & seg_in[cb];
            end
            seg_out = seg_mrg;
            if (open_en && (int'(open_wire) >= BASE) && (int'(open_wire) < BASE + SEG)) begin
                seg_out[int'(open_wire) - BASE] = 1'b0;
            end
            if (pdisc_en && (int'(pdisc_mtx) == g) && (pdisc_pa != pdisc_pb) &&
                (da == db) && (int'(pdisc_pa) < 4 * K) && (int'(pdisc_pb) < 4 * K)) begin
                seg_out[da] = 1'b0;
            end
        end

        assign rcv[BASE +: SEG] = seg_out;
    end

    // R3
    clean_fabric_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_en || short_en || pconn_en || pdisc_en) |-> (rcv == drv));

endmodule

// File: rtl/sm_rx_check.sv
module sm_rx_check #(
    parameter int K = 4,
    parameter int M = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                run,
    input  logic [CWI-1:0]      vec_idx,
    input  logic [2*K*M-1:0]    rcv,
    output logic                fail
);
    localparam int NW  = 2 * K * M;
    localparam int CW  = $clog2(NW + 2);
    localparam int CWI = (CW > 1) ? $clog2(CW) : 1;

    typedef struct packed {
        logic fail;
    } chk_t;

    chk_t chk_d, chk_q;
    logic [NW-1:0] expect_v;
    logic mismatch;

    for (genvar w = 0; w < NW; w++) begin : g_exp
        localparam logic [CW-1:0] CODE = CW'(w + 1);
        assign expect_v[w] = CODE[vec_idx];
    end

    always_comb begin
        chk_d    = chk_q;
        mismatch = run && (rcv != expect_v);
        if (clear) begin
            chk_d.fail = 1'b0;
        end else if (mismatch) begin
            chk_d.fail = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_q <= '{fail: 1'b0};
        end else begin
            chk_q <= chk_d;
        end
    end

    assign fail = chk_q.fail;

    // R8
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clear) |=> fail);

    // R8
    fail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !fail);

endmodule

// File: rtl/sm_row_ictest.sv
module sm_row_ictest
    import sm_ictest_pkg::*;
#(
    parameter int K = 4,
    parameter int M = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          mode,
    input  logic                open_en,
    input  logic [WIW-1:0]      open_wire,
    input  logic                short_en,
    input  logic [WIW-1:0]      short_a,
    input  logic [WIW-1:0]      short_b,
    input  logic                pconn_en,
    input  logic [MIW-1:0]      pconn_mtx,
    input  logic [PIW-1:0]      pconn_pa,
    input  logic [PIW-1:0]      pconn_pb,
    input  logic                pdisc_en,
    input  logic [MIW-1:0]      pdisc_mtx,
    input  logic [PIW-1:0]      pdisc_pa,
    input  logic [PIW-1:0]      pdisc_pb,
    output logic                done,
    output logic                fail,
    output logic                pass
);
    localparam int NW  = 2 * K * M;
    localparam int CW  = $clog2(NW + 2);
    localparam int CWI = (CW > 1) ? $clog2(CW) : 1;
    localparam int WIW = $clog2(NW);
    localparam int MIW = (M > 1) ? $clog2(M) : 1;
    localparam int PIW = $clog2(4 * K);

    logic           run, clear;
    cfg_mode_t      mode_q;
    logic [CWI-1:0] vec_idx;
    logic [NW-1:0]  drv, rcv;

    sm_seq_ctl #(.K(K), .M(M)) u_ctl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode),
        .run(run), .clear(clear), .done(done), .mode_q(mode_q),
        .vec_idx(vec_idx), .drv(drv)
    );

    sm_fabric #(.K(K), .M(M)) u_fab (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .drv(drv),
        .open_en(open_en), .open_wire(open_wire),
        .short_en(short_en), .short_a(short_a), .short_b(short_b),
        .pconn_en(pconn_en), .pconn_mtx(pconn_mtx),
        .pconn_pa(pconn_pa), .pconn_pb(pconn_pb),
        .pdisc_en(pdisc_en), .pdisc_mtx(pdisc_mtx),
        .pdisc_pa(pdisc_pa), .pdisc_pb(pdisc_pb),
        .rcv(rcv)
    );

    sm_rx_check #(.K(K), .M(M)) u_chk (
        .clk(clk), .rst_n(rst_n), .clear(clear), .run(run),
        .vec_idx(vec_idx), .rcv(rcv), .fail(fail)
    );

    assign pass = done & ~fail;

    // R2
    no_done_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !done);

endmodule

// File: tb/sim_sm_row_ictest.sv
module sim_sm_row_ictest;
    localparam int K  = 4;
    localparam int M  = 5;
    localparam int NW = 2 * K * M;
    localparam int CW = $clog2(NW + 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic open_en = 1'b0, short_en = 1'b0, pconn_en = 1'b0, pdisc_en = 1'b0;
    logic [5:0] open_wire = '0, short_a = '0, short_b = '0;
    logic [2:0] pconn_mtx = '0, pdisc_mtx = '0;
    logic [3:0] pconn_pa = '0, pconn_pb = '0, pdisc_pa = '0, pdisc_pb = '0;
    logic done, fail, pass;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    sm_row_ictest #(.K(K), .M(M)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .open_en(open_en), .open_wire(open_wire),
        .short_en(short_en), .short_a(short_a), .short_b(short_b),
        .pconn_en(pconn_en), .pconn_mtx(pconn_mtx), .pconn_pa(pconn_pa), .pconn_pb(pconn_pb),
        .pdisc_en(pdisc_en), .pdisc_mtx(pdisc_mtx), .pdisc_pa(pdisc_pa), .pdisc_pb(pdisc_pb),
        .done(done), .fail(fail), .pass(pass)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Joined pair per mode: N=0 E=1 S=2 W=3, pin = side*K+i
    function automatic bit joined(input logic [1:0] md, input int pa, input int pb);
        int sa, sb, msk;
        sa = pa / K; sb = pb / K;
        if ((pa % K) != (pb % K) || sa == sb) return 0;
        msk = (1 << sa) | (1 << sb);
        case (md)
            2'd1:    return (msk == 9) || (msk == 6);
            2'd2:    return (msk == 12) || (msk == 3);
            default: return (msk == 10) || (msk == 5);
        endcase
    endfunction

    task automatic clear_faults();
        open_en = 0; short_en = 0; pconn_en = 0; pdisc_en = 0;
    endtask

    // Run one test; faults already set. mid_start pulses start during the run.
    task automatic do_run(input string req, input logic exp_fail, input bit mid_start);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R2 done low after start", done, 1'b0);
        for (int c = 1; c < CW; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (mid_start && c == 2) start = 1'b1;
            if (mid_start && c == 3) start = 1'b0;
        end
        check(mid_start ? "R9 done timing with extra start" : "R2 done before final edge", done, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check(mid_start ? "R9 done raised on time" : "R2 done raised", done, 1'b1);
        check(req, fail, exp_fail);
        check("R8 pass equals done and not fail", pass, ~exp_fail);
    endtask

    initial begin : main
        int kind, pa, pb, w1, w2;
        logic [1:0] md;
        bit ef;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 done at reset", done, 1'b0);
        check("R1 fail at reset", fail, 1'b0);
        check("R1 pass at reset", pass, 1'b0);
        rst_n = 1'b1;

        // R3: every mode clean, including reserved value
        for (int m = 0; m < 4; m++) begin
            mode = m[1:0]; clear_faults();
            do_run("R3 clean run", 1'b0, 0);
        end
        // R2: done holds
        repeat (4) @(negedge clk);
        check("R2 done holds until start", done, 1'b1);

        // R4 directed: first and last wire
        open_en = 1; open_wire = 6'd0; do_run("R4 open wire 0", 1'b1, 0);
        open_wire = 6'(NW - 1); do_run("R4 open last wire", 1'b1, 0);
        clear_faults();
        // R8: fail cleared by new clean run
        do_run("R8 fail cleared by start", 1'b0, 0);

        // R5 directed
        short_en = 1; short_a = 6'd3; short_b = 6'd4; do_run("R5 short adjacent", 1'b1, 0);
        short_a = 6'd7; short_b = 6'd7; do_run("R5 short same wire ignored", 1'b0, 0);
        clear_faults();

        // R6 directed: mode 1 joins W0(12) with N0(0); different-index pins 1 and 6
        mode = 2'd1; pconn_en = 1; pconn_mtx = 3'd4;
        pconn_pa = 4'd12; pconn_pb = 4'd0; do_run("R6 connection on joined pair", 1'b0, 0);
        pconn_pa = 4'd1; pconn_pb = 4'd6; do_run("R6 connection across indices", 1'b1, 0);
        mode = 2'd0; pconn_pa = 4'd12; pconn_pb = 4'd0; do_run("R6 same pins in ortho", 1'b1, 0);
        clear_faults();

        // R7 directed: mode 2 joins N1(1) with E1(5)
        mode = 2'd2; pdisc_en = 1; pdisc_mtx = 3'd2;
        pdisc_pa = 4'd1; pdisc_pb = 4'd5; do_run("R7 disconnect joined pair", 1'b1, 0);
        mode = 2'd0; do_run("R7 disconnect unjoined pair", 1'b0, 0);
        clear_faults();

        // R9: start during run, fault present, mode changed mid-run
        mode = 2'd2; pdisc_en = 1; pdisc_mtx = 3'd0; pdisc_pa = 4'd15; pdisc_pb = 4'd11;
        fork
            do_run("R9 mode kept despite extra start", 1'b1, 1);
            begin repeat (3) @(negedge clk); mode = 2'd0; end
        join
        clear_faults();

        // Random trials
        for (int t = 0; t < 80; t++) begin
            clear_faults();
            kind = $urandom % 5;
            md = 2'($urandom % 4);
            mode = md;
            ef = 0;
            w1 = $urandom % NW; w2 = $urandom % NW;
            pa = $urandom % (4 * K); pb = $urandom % (4 * K);
            case (kind)
                1: begin open_en = 1; open_wire = 6'(w1); ef = 1; end
                2: begin short_en = 1; short_a = 6'(w1); short_b = 6'(w2); ef = (w1 != w2); end
                3: begin
                    pconn_en = 1; pconn_mtx = 3'($urandom % M);
                    pconn_pa = 4'(pa); pconn_pb = 4'(pb);
                    ef = (pa != pb) && !joined(md, pa, pb);
                end
                4: begin
                    pdisc_en = 1; pdisc_mtx = 3'($urandom % M);
                    pdisc_pa = 4'(pa); pdisc_pb = 4'(pb);
                    ef = joined(md, pa, pb);
                end
                default: ef = 0;
            endcase
            case (kind)
                1: do_run("R4 random open", ef, 0);
                2: do_run("R5 random short", ef, 0);
                3: do_run("R6 random connection", ef, 0);
                4: do_run("R7 random disconnection", ef, 0);
                default: do_run("R3 random clean", ef, 0);
            endcase
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule